// File: doc/BRIEF.md
# Cache-Block Fault Resolver

This block sits at the end of the access-check path for a cache-block management operation (clean, flush, invalidate). Address translation and the physical permission checkers run elsewhere; each reports a fault flag and a fault kind to this block. The resolver turns those reports into one result: either the operation may proceed, or it must trap with a store-class exception.

An operation on a block is allowed when a read or a write to that block would be allowed, so a permission fault is raised only when both checks fail. In that case the write check's fault is reported. A translation fault is reported directly, and the permission checks are not looked at. Every reported load-class fault is turned into the store-class fault of the same type. Fetch permission never grants access. A reported kind outside the expected set raises an internal-error flag.

A request is presented with a one-cycle `reqValid` strobe. The result appears one cycle later with a `done` pulse and stays on the outputs until the next request.

Top module: `cbo_fault_resolver`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle with `reqValid` high, and low otherwise.
- R2: With no translation fault and at least one of the read and write permission checks passing, the result is `fault`=0, `excCode`=0, `cause`=0 and `intErr`=0. The fault kinds are ignored.
- R3: With no translation fault and both permission checks failing, the result is a fault derived from `wrKind`. `rdKind` has no effect.
- R4: A translation fault takes priority. The result is derived from `xlatKind`, and the permission inputs have no effect.
- R5: Kind encoding is 0 load access, 1 load page, 2 store access, 3 store page. Kinds 0 and 2 give `excCode`=1 and `cause`=7. Kinds 1 and 3 give `excCode`=2 and `cause`=15.
- R6: When `fault` is 0, `excCode` and `cause` are 0. When `fault` is 1, `cause` is 7 or 15.
- R7: `fault`, `excCode`, `cause` and `intErr` keep their values in every cycle that follows a cycle without `reqValid`.
- R8: A reported kind of 4 to 7 (fetch or misaligned kinds) gives `fault`=1, `excCode`=1, `cause`=7 and `intErr`=1.
- R9: After reset, `done`, `fault`, `excCode`, `cause` and `intErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| xlatFault | input | 1 | Translation failed |
| xlatKind | input | 3 | Kind of translation fault |
| rdFault | input | 1 | Read permission check failed |
| rdKind | input | 3 | Kind of read permission fault |
| wrFault | input | 1 | Write permission check failed |
| wrKind | input | 3 | Kind of write permission fault |
| done | output | 1 | Result strobe, one cycle after the request |
| fault | output | 1 | Operation must trap |
| excCode | output | 2 | 0 none, 1 store access fault, 2 store page fault |
| cause | output | 5 | Exception cause number (0, 7 or 15) |
| intErr | output | 1 | Unexpected fault kind was reported |

## Verification
Two situations can occur in the same request. A translation fault can arrive together with a double permission failure. A kind rewrite can combine with an unexpected-kind internal error. Random stimulus sets all three fault flags independently and draws kinds from the full 3-bit range. Directed cases force translation and write kinds that differ, and back-to-back requests make a new request fall in the cycle of the previous `done`. Each result is compared with a bench model in which the translation fault takes priority, the write kind is used only when both permission checks fail, and the hold behaviour is checked after the inputs are scrambled while `reqValid` is low.

// File: rtl/cbo_fault_pkg.sv
package cbo_fault_pkg;
  localparam int KIND_W  = 3;
  localparam int CODE_W  = 2;
  localparam int CAUSE_W = 5;

  localparam logic [KIND_W-1:0] KIND_LD_ACC = 3'd0;
  localparam logic [KIND_W-1:0] KIND_LD_PG  = 3'd1;
  localparam logic [KIND_W-1:0] KIND_ST_ACC = 3'd2;
  localparam logic [KIND_W-1:0] KIND_ST_PG  = 3'd3;

  typedef enum logic [CODE_W-1:0] {
    CODE_NONE   = 2'd0,
    CODE_ST_ACC = 2'd1,
    CODE_ST_PG  = 2'd2
  } excCode_e;

  typedef struct packed {
    logic capture;
    logic done;
  } ctrlStrobes_t;

  typedef struct packed {
    logic     fault;
    excCode_e code;
    logic     intErr;
  } result_t;
endpackage

// File: rtl/cbo_fault_ctrl.sv
module cbo_fault_ctrl
  import cbo_fault_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output ctrlStrobes_t strobes
);
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= reqValid;
  end

  always_comb begin
    strobes.capture = reqValid && rstN;
    strobes.done    = doneQ;
  end
endmodule

// File: rtl/cbo_fault_dp.sv
module cbo_fault_dp
  import cbo_fault_pkg::*;
#(
  parameter int                 KW        = KIND_W,
  parameter int                 CW        = CAUSE_W,
  parameter logic [CAUSE_W-1:0] CAUSE_ACC = 5'd7,
  parameter logic [CAUSE_W-1:0] CAUSE_PG  = 5'd15
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic          xlatFault,
  input  logic [KW-1:0] xlatKind,
  input  logic          rdFault,
  input  logic [KW-1:0] rdKind,
  input  logic          wrFault,
  input  logic [KW-1:0] wrKind,
  output result_t       result,
  output logic [CW-1:0] cause
);
  logic          needFault;
  logic [KW-1:0] chosenKind;
  result_t       nextRes;
  result_t       resQ;

  // Source selection: translation first, then double permission failure.
  always_comb begin
    needFault  = 1'b0;
    chosenKind = KIND_LD_ACC;
    if (xlatFault) begin
      needFault  = 1'b1;
      chosenKind = xlatKind;
    end else if (rdFault && wrFault) begin
      needFault  = 1'b1;
      chosenKind = wrKind;
    end
  end

  // Load-to-store rewrite and unexpected-kind detection.
  always_comb begin
    nextRes.fault  = needFault;
    nextRes.code   = CODE_NONE;
    nextRes.intErr = 1'b0;
    if (needFault) begin
      unique case (chosenKind)
        KIND_LD_ACC, KIND_ST_ACC: nextRes.code = CODE_ST_ACC;
        KIND_LD_PG,  KIND_ST_PG:  nextRes.code = CODE_ST_PG;
        default: begin
          nextRes.code   = CODE_ST_ACC;
          nextRes.intErr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                resQ <= '0;
    else if (strobes.capture) resQ <= nextRes;
  end

  always_comb begin
    result = resQ;
    unique case (resQ.code)
      CODE_ST_ACC: cause = CAUSE_ACC;
      CODE_ST_PG:  cause = CAUSE_PG;
      default:     cause = '0;
    endcase
  end
endmodule

// File: rtl/cbo_fault_resolver.sv
module cbo_fault_resolver
  import cbo_fault_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               xlatFault,
  input  logic [KIND_W-1:0]  xlatKind,
  input  logic               rdFault,
  input  logic [KIND_W-1:0]  rdKind,
  input  logic               wrFault,
  input  logic [KIND_W-1:0]  wrKind,
  output logic               done,
  output logic               fault,
  output logic [CODE_W-1:0]  excCode,
  output logic [CAUSE_W-1:0] cause,
  output logic               intErr
);
  ctrlStrobes_t strobes;
  result_t      result;

  cbo_fault_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .strobes(strobes)
  );

  cbo_fault_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .xlatFault(xlatFault), .xlatKind(xlatKind),
    .rdFault(rdFault), .rdKind(rdKind),
    .wrFault(wrFault), .wrKind(wrKind),
    .result(result), .cause(cause)
  );

  assign done    = strobes.done;
  assign fault   = result.fault;
  assign excCode = result.code;
  assign intErr  = result.intErr;
endmodule

// File: rtl/cbo_fault_resolver_chk.sv
module cbo_fault_resolver_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       xlatFault,
  input logic [2:0] xlatKind,
  input logic       rdFault,
  input logic       wrFault,
  input logic       done,
  input logic       fault,
  input logic [1:0] excCode,
  input logic [4:0] cause,
  input logic       intErr
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> done); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !done); // R1
  AST_ONE_CHECK_GRANTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !xlatFault && !(rdFault && wrFault)) |=> (!fault && !intErr)); // R2
  AST_XLAT_PAGE_PRIO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && xlatFault && xlatKind == 3'd1) |=> (fault && cause == 5'd15)); // R4
  AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (cause == 5'd7 || cause == 5'd15)); // R6
  AST_QUIET_WHEN_OK: assert property (@(posedge clk) disable iff (!rstN)
    !fault |-> (cause == 5'd0 && excCode == 2'd0)); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(fault) && $stable(excCode) && $stable(cause) && $stable(intErr))); // R7
  AST_ERR_IMPLIES_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    intErr |-> (fault && cause == 5'd7)); // R8
endmodule

bind cbo_fault_resolver cbo_fault_resolver_chk chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid),
  .xlatFault(xlatFault), .xlatKind(xlatKind),
  .rdFault(rdFault), .wrFault(wrFault),
  .done(done), .fault(fault), .excCode(excCode),
  .cause(cause), .intErr(intErr)
);

// File: tb/cbo_fault_resolver_tb_top.sv
module cbo_fault_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       xlatFault = 1'b0, rdFault = 1'b0, wrFault = 1'b0;
  logic [2:0] xlatKind = '0, rdKind = '0, wrKind = '0;
  logic       done, fault, intErr;
  logic [1:0] excCode;
  logic [4:0] cause;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cbo_fault_resolver dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .xlatFault(xlatFault), .xlatKind(xlatKind),
    .rdFault(rdFault), .rdKind(rdKind),
    .wrFault(wrFault), .wrKind(wrKind),
    .done(done), .fault(fault), .excCode(excCode),
    .cause(cause), .intErr(intErr)
  );

  // Expected result packed as {fault, code[1:0], cause[4:0], intErr}
  function automatic logic [8:0] model(input logic xf, input logic [2:0] xk,
                                       input logic rf, input logic wf,
                                       input logic [2:0] wk);
    logic [2:0] k;
    if (xf) k = xk;
    else if (rf && wf) k = wk;
    else return 9'd0;
    case (k)
      3'd0, 3'd2: return {1'b1, 2'd1, 5'd7, 1'b0};
      3'd1, 3'd3: return {1'b1, 2'd2, 5'd15, 1'b0};
      default:    return {1'b1, 2'd1, 5'd7, 1'b1};
    endcase
  endfunction

  function automatic string tagOf(input logic xf, input logic rf, input logic wf);
    if (xf) return "R4/R5/R8";
    if (rf && wf) return "R3/R5/R8";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (done,fault,code,cause,intErr)", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] outs();
    return {done, fault, excCode, cause, intErr};
  endfunction

  // Drive one request, then check the result one cycle later (R1) and the hold (R7).
  task automatic doReq(input logic xf, input logic [2:0] xk, input logic rf,
                       input logic [2:0] rk, input logic wf, input logic [2:0] wk);
    logic [8:0] e;
    e = model(xf, xk, rf, wf, wk);
    @(negedge clk);
    xlatFault = xf; xlatKind = xk; rdFault = rf; rdKind = rk; wrFault = wf; wrKind = wk;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check({"R1 ", tagOf(xf, rf, wf)}, outs(), {1'b1, e});
    xlatFault = ~xf; xlatKind = ~xk; rdFault = ~rf; rdKind = ~rk; wrFault = ~wf; wrKind = ~wk;
    @(negedge clk);
    check("R7 R1 hold", outs(), {1'b0, e});
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    check("R9 reset", outs(), 10'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 after release", outs(), 10'd0);

    // Directed corners
    doReq(0, 3'd1, 1, 3'd1, 0, 3'd3);   // R2 read fails only
    doReq(0, 3'd1, 0, 3'd1, 1, 3'd3);   // R2 write fails only
    doReq(0, 3'd0, 1, 3'd1, 1, 3'd0);   // R3 write kind wins, R5 load acc -> 7
    doReq(0, 3'd0, 1, 3'd0, 1, 3'd1);   // R3 + R5 load page -> 15
    doReq(0, 3'd0, 1, 3'd0, 1, 3'd3);   // R5 store page pass-through
    doReq(1, 3'd1, 1, 3'd0, 1, 3'd0);   // R4 xlat page wins over perms
    doReq(1, 3'd0, 0, 3'd0, 0, 3'd0);   // R4 xlat access
    doReq(1, 3'd2, 1, 3'd1, 1, 3'd3);   // R4 store access
    doReq(1, 3'd5, 1, 3'd0, 1, 3'd0);   // R8 fetch kind on translation
    doReq(0, 3'd0, 1, 3'd0, 1, 3'd6);   // R8 misaligned on write check
    doReq(0, 3'd0, 1, 3'd4, 0, 3'd7);   // R2 bad kinds ignored when granted

    // Back-to-back requests: new request in the done cycle (R1)
    @(negedge clk);
    xlatFault = 1; xlatKind = 3'd1; rdFault = 0; wrFault = 0; reqValid = 1'b1;
    @(negedge clk);
    check("R1 R4 back-to-back first", outs(), {1'b1, model(1, 3'd1, 0, 0, 3'd0)});
    xlatFault = 0; rdFault = 1; wrFault = 1; wrKind = 3'd0;
    @(negedge clk);
    reqValid = 1'b0;
    check("R1 R3 back-to-back second", outs(), {1'b1, model(0, 3'd0, 1, 1, 3'd0)});

    // Constrained random
    for (int i = 0; i < 300; i++) begin
      logic [2:0] a, b, c;
      a = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 4);
      b = 3'($urandom);
      c = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 4);
      doReq(1'($urandom), a, 1'($urandom), b, 1'($urandom), c);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule